// File: doc/BRIEF.md
# Sub-word load/store lane aligner

This block sits between a 32-bit core and a memory that is one word wide. It turns sub-word memory traffic into full-word traffic. On a load, the core passes in the fetched word, the two low address bits, an access size and a signed/unsigned flag. The block picks out the addressed byte or halfword and extends it to 32 bits. On a store, the core passes in the source register value, the size and the low address bits. The block returns a write word with the data copied into every lane, together with four byte enables that mark the lanes the memory should actually write.

The block also checks each request against a table of legal offsets for each size. It raises an error flag for any access that breaks the table, and in that case it suppresses the write. Address generation and the memory are outside this block.

One request may be presented on every cycle. Each result appears, registered, on the cycle after its request.

Top module: `lane_align`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises with no request, resp_valid, misalign_err, load_result, store_word and store_be are all zero.
- R2: resp_valid is high in exactly the cycle after a cycle with req_valid high, and all outputs for that request are presented in that cycle.
- R3: The size encoding is 00 for a byte, 01 for a halfword, 10 for a word and 11 reserved. Bytes are legal at offsets 0, 1, 2 and 3. Halfwords are legal only at offsets 0 and 2. Words are legal only at offset 0. The reserved size is never legal. misalign_err is high exactly for an access that is not legal.
- R4: An unsigned legal byte or halfword load returns the addressed lane with zeros above it. Lanes are little-endian: offset k selects bits 8k+7:8k for a byte, offset 0 selects bits 15:0 for a halfword and offset 2 selects bits 31:16.
- R5: A signed legal byte or halfword load copies bit 7 (byte) or bit 15 (halfword) of the extracted value into all upper bits of load_result.
- R6: A legal word load returns load_word unchanged, whatever the value of req_signed.
- R7: A legal store returns store_word equal to {4{data[7:0]}} for a byte, {2{data[15:0]}} for a halfword, and data for a word.
- R8: A legal store drives store_be as follows: 4'b0001 shifted left by the offset for a byte; 4'b0011 at offset 0 or 4'b1100 at offset 2 for a halfword; 4'b1111 for a word.
- R9: A misaligned access returns store_be, store_word and load_result all zero.
- R10: A load returns store_be and store_word zero. A store returns load_result zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_signed | input | 1 | Sign-extend a sub-word load |
| req_addr_lo | input | 2 | Low two address bits (lane offset) |
| load_word | input | 32 | Word fetched from memory for a load |
| store_data | input | 32 | Register value to be stored |
| resp_valid | output | 1 | Result present this cycle |
| load_result | output | 32 | Extended load value |
| store_word | output | 32 | Lane-replicated write data |
| store_be | output | 4 | Byte enables for the write |
| misalign_err | output | 1 | Access broke the offset table |

## Verification
The block holds only one register stage, so a wrong internal value shows up at the ports in the response cycle of the request that caused it. An offset decoded into the wrong lane shows up as a wrong byte in load_result or as an enable on the wrong lane. A flipped legality decision shows up as an error flag together with enables that are not zero, or as a write that passes when it should be suppressed. The bench sweeps every combination of direction, size, sign and offset over several data patterns, so that each of these faults reaches a port.

// File: rtl/lane_align.sv
module lane_align #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic [1:0]        req_addr_lo,
  input  logic [DATA_W-1:0] load_word,
  input  logic [DATA_W-1:0] store_data,
  output logic              resp_valid,
  output logic [DATA_W-1:0] load_result,
  output logic [DATA_W-1:0] store_word,
  output logic [3:0]        store_be,
  output logic              misalign_err
);
  localparam int LANES = DATA_W / 8;
  localparam int HALF_W = DATA_W / 2;

  logic              legal;
  logic [7:0]        lane_b;
  logic [HALF_W-1:0] lane_h;
  logic [DATA_W-1:0] ld_val, st_val;
  logic [LANES-1:0]  be_val;

  always_comb begin
    case (req_size)
      2'b00:   legal = 1'b1;
      2'b01:   legal = ~req_addr_lo[0];
      2'b10:   legal = (req_addr_lo == 2'b00);
      default: legal = 1'b0;
    endcase
  end

  assign lane_b = load_word[8*req_addr_lo +: 8];
  assign lane_h = req_addr_lo[1] ? load_word[DATA_W-1:HALF_W] : load_word[HALF_W-1:0];

  always_comb begin
    case (req_size)
      2'b00: begin
        ld_val = {{(DATA_W-8){req_signed & lane_b[7]}}, lane_b};
        st_val = {LANES{store_data[7:0]}};
        be_val = 4'b0001 << req_addr_lo;
      end
      2'b01: begin
        ld_val = {{(DATA_W-HALF_W){req_signed & lane_h[HALF_W-1]}}, lane_h};
        st_val = {2{store_data[HALF_W-1:0]}};
        be_val = req_addr_lo[1] ? 4'b1100 : 4'b0011;
      end
      default: begin
        ld_val = load_word;
        st_val = store_data;
        be_val = 4'b1111;
      end
    endcase
  end

  logic       store_q, signed_q;
  logic [1:0] size_q, ofs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid   <= 1'b0;
      misalign_err <= 1'b0;
      load_result  <= '0;
      store_word   <= '0;
      store_be     <= '0;
      store_q      <= 1'b0;
      signed_q     <= 1'b0;
      size_q       <= 2'b00;
      ofs_q        <= 2'b00;
    end else begin
      resp_valid <= req_valid;
      if (req_valid) begin
        misalign_err <= ~legal;
        load_result  <= (legal && !req_store) ? ld_val : '0;
        store_word   <= (legal && req_store) ? st_val : '0;
        store_be     <= (legal && req_store) ? be_val : '0;
        store_q      <= req_store;
        signed_q     <= req_signed;
        size_q       <= req_size;
        ofs_q        <= req_addr_lo;
      end
    end
  end

  assert_resp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);
  assert_resp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);
  assert_word_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && size_q == 2'b10 && ofs_q != 2'b00) |-> misalign_err);
  assert_half_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && size_q == 2'b01 && ofs_q[0]) |-> misalign_err);
  assert_unsigned_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !store_q && !signed_q && size_q == 2'b00) |-> (load_result[DATA_W-1:8] == '0));
  assert_word_be_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && store_q && size_q == 2'b10 && !misalign_err) |-> (store_be == 4'b1111));
  assert_byte_be_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && store_q && size_q == 2'b00) |-> ($countones(store_be) == 1));
  assert_err_blocks_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && misalign_err) |-> (store_be == 4'b0000 && load_result == '0));
  assert_load_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !store_q) |-> (store_be == 4'b0000));
endmodule

// File: tb/test_lane_align.sv
module test_lane_align;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_signed = 1'b0;
  logic [1:0]  req_size = 2'b00, req_addr_lo = 2'b00;
  logic [31:0] load_word = '0, store_data = '0;
  logic        resp_valid, misalign_err;
  logic [31:0] load_result, store_word;
  logic [3:0]  store_be;

  always #5 clk = ~clk;

  lane_align i_lane_align (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_signed(req_signed), .req_addr_lo(req_addr_lo),
    .load_word(load_word), .store_data(store_data), .resp_valid(resp_valid),
    .load_result(load_result), .store_word(store_word), .store_be(store_be),
    .misalign_err(misalign_err)
  );

  typedef struct {
    logic        err;
    logic [31:0] res;
    logic [31:0] wr;
    logic [3:0]  be;
    logic        st;
    logic [1:0]  sz;
    logic        sg;
  } exp_t;

  exp_t sb[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  function automatic exp_t model(logic st, logic [1:0] sz, logic sg, logic [1:0] ofs,
                                 logic [31:0] lw, logic [31:0] sd);
    exp_t e;
    logic ok;
    logic [7:0] b;
    logic [15:0] h;
    ok = (sz == 2'd0) || (sz == 2'd1 && (ofs == 2'd0 || ofs == 2'd2)) || (sz == 2'd2 && ofs == 2'd0);
    b = lw[8*ofs +: 8];
    h = (ofs == 2'd2) ? lw[31:16] : lw[15:0];
    e.err = !ok; e.st = st; e.sz = sz; e.sg = sg;
    e.res = '0; e.wr = '0; e.be = '0;
    if (ok && !st) begin
      if (sz == 2'd0) e.res = sg ? 32'(signed'(b)) : {24'd0, b};
      else if (sz == 2'd1) e.res = sg ? 32'(signed'(h)) : {16'd0, h};
      else e.res = lw;
    end
    if (ok && st) begin
      if (sz == 2'd0) begin e.wr = {sd[7:0], sd[7:0], sd[7:0], sd[7:0]}; e.be = 4'(1 << ofs); end
      else if (sz == 2'd1) begin e.wr = {sd[15:0], sd[15:0]}; e.be = (ofs == 2'd2) ? 4'b1100 : 4'b0011; end
      else begin e.wr = sd; e.be = 4'b1111; end
    end
    return e;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(logic st, logic [1:0] sz, logic sg, logic [1:0] ofs,
                       logic [31:0] lw, logic [31:0] sd);
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_size = sz; req_signed = sg;
    req_addr_lo = ofs; load_word = lw; store_data = sd;
    sb.push_back(model(st, sz, sg, ofs, lw, sd));
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: compares each response against the front of the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (resp_valid) begin
        if (sb.size() == 0) check("R2", "unexpected resp_valid", 32'd1, 32'd0);
        else begin
          exp_t e;
          string rtag;
          e = sb.pop_front();
          check("R3", "misalign_err", {31'd0, misalign_err}, {31'd0, e.err});
          if (e.err) begin
            check("R9", "store_be", {28'd0, store_be}, 32'd0);
            check("R9", "load_result", load_result, 32'd0);
            check("R9", "store_word", store_word, 32'd0);
          end else if (e.st) begin
            check("R7", "store_word", store_word, e.wr);
            check("R8", "store_be", {28'd0, store_be}, {28'd0, e.be});
            check("R10", "load_result on store", load_result, 32'd0);
          end else begin
            rtag = (e.sz == 2'd2) ? "R6" : (e.sg ? "R5" : "R4");
            check(rtag, "load_result", load_result, e.res);
            check("R10", "store_be on load", {28'd0, store_be}, 32'd0);
            check("R10", "store_word on load", store_word, 32'd0);
          end
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [3];
    pats[0] = 32'h8F7E_6D5C;
    pats[1] = 32'h1234_F0A5;
    pats[2] = 32'h80FF_7F01;
    repeat (3) @(negedge clk);
    // R1: outputs zero during reset
    check("R1", "resp_valid in reset", {31'd0, resp_valid}, 32'd0);
    check("R1", "outputs in reset", load_result | store_word | {28'd0, store_be} | {31'd0, misalign_err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "resp_valid after reset", {31'd0, resp_valid}, 32'd0);
    check("R1", "outputs after reset", load_result | store_word | {28'd0, store_be} | {31'd0, misalign_err}, 32'd0);
    // R2 directed: a single request yields exactly one response
    drive(1'b0, 2'd0, 1'b1, 2'd3, 32'hF000_0000, 32'd0);
    idle();
    @(negedge clk);
    check("R2", "resp_valid after idle", {31'd0, resp_valid}, 32'd0);
    // R5 directed sign corner: byte 0x80 at offset 1
    drive(1'b0, 2'd0, 1'b1, 2'd1, 32'h0000_8000, 32'd0);
    // R8 directed: halfword store at offset 2
    drive(1'b1, 2'd1, 1'b0, 2'd2, 32'd0, 32'hDEAD_BEEF);
    // full sweep, back to back
    for (int p = 0; p < 3; p++)
      for (int st = 0; st < 2; st++)
        for (int sz = 0; sz < 4; sz++)
          for (int sg = 0; sg < 2; sg++)
            for (int ofs = 0; ofs < 4; ofs++)
              drive(st[0], sz[1:0], sg[0], ofs[1:0], pats[p], ~pats[p]);
    idle();
    repeat (3) @(negedge clk);
    check("R2", "scoreboard drained", sb.size(), 32'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule